// File: doc/BRIEF.md
# Debounced Matrix Key Scanner

This block reads a key matrix of up to six drive rows by five sense columns whose inputs are pulled low. It does nothing while every sense line is low. When any sense line goes high, it walks the drive rows one at a time over a fixed scan period and then repeats that scan. It keeps the result only when both 30-bit images agree. A matching, non-empty image is latched as the key image. An active-low request is then pulled down and held until the serial block reports that the host has read the image. While the request is pending no new scan starts.

The number of usable rows depends on a key-count select and a power-save select. These inputs decide which rows are scanned, which key bits always read zero, and what level each drive row rests at between scans. All timing is counted in oscillator ticks. The tick is a one-clock strobe on the system clock.

The controller has four states. IDLE waits for a sense line. SCAN runs back-to-back scan pairs. WAIT covers the last tick before the request. HOLD keeps the image frozen and the request low. The transitions are as follows. Start goes from IDLE to SCAN on a tick with any sense line high. Restart goes from SCAN back into SCAN when the pair differs and a key is still seen. Give-up goes from SCAN to IDLE when the second image is empty. Accept goes from SCAN to WAIT when the pair matches and is non-empty. Post goes from WAIT to HOLD after the remaining ticks. Release goes from HOLD to IDLE on read-done.

Top module: `keyscan_top`

## Requirements
- R1: After reset, req_n is 1, key_img is all zero, no scan runs, and drive rests at the idle level of the current power-save select.
- R2: A scan starts on the first tick in IDLE with any sense line high. One scan lasts 288 ticks, split into six equal 48-tick row shares in row order 0 to 5. During a share only that row's drive line is high, and only if the row is enabled. All drive lines are low in a disabled row's share.
- R3: A pair of scans is accepted only when both images are equal and not all zero. req_n then goes low on the 577th tick after the start tick and stays high on the 576th.
- R4: If the two images differ and the second is non-zero, a new pair starts at once. If the second image is all zero, the block returns to IDLE and raises no request.
- R5: While the request is pending, no scan runs and key_img does not change, whatever the sense lines do.
- R6: A read_done pulse while the request is pending releases it (req_n back to 1) and returns to IDLE. read_done at any other time has no effect.
- R7: While host_wr is 1, req_n is 1. When host_wr drops and no read has completed, req_n is low again.
- R8: Key bit 5*r + c of key_img belongs to drive row r (0 to 5) and sense column c (0 to 4).
- R9: keysel 00 enables all six rows. keysel 01 disables row 0. keysel 1x disables rows 0 and 1. Key bits of a disabled row read 0.
- R10: Between scans, drive rests at these levels. psmode 00 and 11 drive all rows high. psmode 01 drives only row 5 high. psmode 10 drives rows 4 and 5 high. Rows that rest low are not scanned and their key bits read 0.
- R11: ps_flag is 1 whenever psmode is non-zero and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-clock strobe per oscillator period |
| sense | input | 5 | Matrix sense columns, pulled low |
| keysel | input | 2 | Key-count select |
| psmode | input | 2 | Power-save select |
| rd_done | input | 1 | Strobe: host finished reading the image |
| host_wr | input | 1 | High while a host write transaction is open |
| drive | output | 6 | Matrix drive rows |
| key_img | output | 30 | Accepted key image |
| ps_flag | output | 1 | Power-save indicator appended to the image |
| req_n | output | 1 | Active-low read request, open-drain style |

## Verification
The release of a pending request by rd_done and the forcing of req_n high by an open host write can land in the same cycle. The bench provokes this by raising host_wr while the request is low and pulsing rd_done inside that write window. It then drops host_wr. The result is correct only if req_n stays high once the write closes. In a separate window, host_wr is dropped without any read, and req_n must return low. The bench also checks bounce handling: it changes the pressed key between the two scans of a pair, and the request must come one full pair later than usual.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_SCAN,
        KS_WAIT,
        KS_HOLD
    } ks_state_t;

    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_TOP1 = 2'b01,
        PS_TOP2 = 2'b10,
        PS_ALL  = 2'b11
    } ps_sel_t;

endpackage

// File: rtl/keyscan_timer.sv
module keyscan_timer #(
    parameter int ROWS  = 6,
    parameter int SHARE = 48,
    parameter int RW    = $clog2(ROWS),
    parameter int SW    = $clog2(SHARE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    output logic [RW-1:0] row_idx,
    output logic          pass,
    output logic          sample_stb,
    output logic          pair_end
);

    logic [SW-1:0] slot;

    // counters rest at zero whenever the scan is not running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot    <= '0;
            row_idx <= '0;
            pass    <= 1'b0;
        end else if (!run) begin
            slot    <= '0;
            row_idx <= '0;
            pass    <= 1'b0;
        end else if (tick) begin
            if (slot == SW'(SHARE - 1)) begin
                slot <= '0;
                if (row_idx == RW'(ROWS - 1)) begin
                    row_idx <= '0;
                    pass    <= ~pass;
                end else begin
                    row_idx <= row_idx + 1'b1;
                end
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // sample one tick before the share ends
    assign sample_stb = run && tick && (slot == SW'(SHARE - 2));
    assign pair_end   = run && tick && pass && (slot == SW'(SHARE - 1))
                        && (row_idx == RW'(ROWS - 1));

    p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= RW'(ROWS - 1));

endmodule

// File: rtl/keyscan_capture.sv
module keyscan_capture #(
    parameter int ROWS = 6,
    parameter int COLS = 5,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic [RW-1:0]        row_idx,
    input  logic                 pass,
    input  logic [COLS-1:0]      sense,
    input  logic [ROWS-1:0]      row_en,
    input  logic                 accept,
    output logic                 img_match,
    output logic                 img_pressed,
    output logic [ROWS*COLS-1:0] key_img
);

    logic [ROWS*COLS-1:0] img_a;
    logic [ROWS*COLS-1:0] img_b;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                img_a[r*COLS +: COLS] <= '0;
                img_b[r*COLS +: COLS] <= '0;
            end else if (sample_stb && row_idx == RW'(r)) begin
                if (pass) img_b[r*COLS +: COLS] <= row_en[r] ? sense : '0;
                else      img_a[r*COLS +: COLS] <= row_en[r] ? sense : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      key_img <= '0;
        else if (accept) key_img <= img_b;
    end

    assign img_match   = (img_a == img_b);
    assign img_pressed = |img_b;

    p_hold_img_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(key_img));

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int WAIT_TICKS = 1,
    parameter int WW         = $clog2(WAIT_TICKS + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      key_any,
    input  logic      pair_end,
    input  logic      img_match,
    input  logic      img_pressed,
    input  logic      rd_done,
    input  logic      host_wr,
    output ks_state_t state,
    output logic      accept,
    output logic      req_n
);

    ks_state_t nxt;
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wcnt <= '0;
        else if (state != KS_WAIT)  wcnt <= '0;
        else if (tick)              wcnt <= wcnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            KS_IDLE: if (tick && key_any) nxt = KS_SCAN;
            KS_SCAN: if (pair_end) begin
                if (img_match && img_pressed) nxt = KS_WAIT;
                else if (img_pressed)         nxt = KS_SCAN;
                else                          nxt = KS_IDLE;
            end
            KS_WAIT: if (tick && wcnt == WW'(WAIT_TICKS - 1)) nxt = KS_HOLD;
            KS_HOLD: if (rd_done) nxt = KS_IDLE;
            default: nxt = KS_IDLE;
        endcase
    end

    always_comb begin
        accept = (state == KS_SCAN) && pair_end && img_match && img_pressed;
        req_n  = (state != KS_HOLD) || host_wr;
    end

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_HOLD && !rd_done) |=> state == KS_HOLD);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_HOLD && rd_done) |=> state == KS_IDLE);

    p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_HOLD && $past(state) != KS_HOLD) |-> $past(state) == KS_WAIT);

endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
    import keyscan_pkg::*;
#(
    parameter int ROWS        = 6,
    parameter int COLS        = 5,
    parameter int CYCLE_TICKS = 288,
    parameter int REQ_TICKS   = 577
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [COLS-1:0]      sense,
    input  logic [1:0]           keysel,
    input  logic [1:0]           psmode,
    input  logic                 rd_done,
    input  logic                 host_wr,
    output logic [ROWS-1:0]      drive,
    output logic [ROWS*COLS-1:0] key_img,
    output logic                 ps_flag,
    output logic                 req_n
);

    localparam int SHARE      = CYCLE_TICKS / ROWS;
    localparam int RW         = $clog2(ROWS);
    localparam int WAIT_TICKS = REQ_TICKS - 2 * CYCLE_TICKS;

    ks_state_t     state;
    logic [RW-1:0] row_idx;
    logic          pass, sample_stb, pair_end, accept;
    logic          img_match, img_pressed;
    logic [ROWS-1:0] idle_hi, row_en;
    logic          scanning;

    assign scanning = (state == KS_SCAN);
    assign ps_flag  = (psmode != PS_OFF);

    for (genvar r = 0; r < ROWS; r++) begin : g_drv
        logic ks_ok;
        assign ks_ok = !((r == 0) && (keysel != 2'b00)) && !((r == 1) && keysel[1]);
        assign idle_hi[r] = (psmode == PS_OFF) || (psmode == PS_ALL)
                            || ((psmode == PS_TOP1) && (r == ROWS - 1))
                            || ((psmode == PS_TOP2) && (r >= ROWS - 2));
        assign row_en[r]  = ks_ok && idle_hi[r];
        assign drive[r]   = scanning ? ((row_idx == RW'(r)) && row_en[r]) : idle_hi[r];
    end

    keyscan_timer #(.ROWS(ROWS), .SHARE(SHARE)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(scanning),
        .row_idx(row_idx), .pass(pass), .sample_stb(sample_stb), .pair_end(pair_end)
    );

    keyscan_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .row_idx(row_idx),
        .pass(pass), .sense(sense), .row_en(row_en), .accept(accept),
        .img_match(img_match), .img_pressed(img_pressed), .key_img(key_img)
    );

    keyscan_ctrl #(.WAIT_TICKS(WAIT_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_any(|sense),
        .pair_end(pair_end), .img_match(img_match), .img_pressed(img_pressed),
        .rd_done(rd_done), .host_wr(host_wr),
        .state(state), .accept(accept), .req_n(req_n)
    );

    p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> $onehot0(drive));

endmodule

// File: tb/sim_keyscan_top.sv
module sim_keyscan_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  sense;
    logic [1:0]  keysel = 2'b00;
    logic [1:0]  psmode = 2'b00;
    logic        rd_done = 1'b0;
    logic        host_wr = 1'b0;
    logic [5:0]  drive;
    logic [29:0] key_img;
    logic        ps_flag;
    logic        req_n;
    logic [29:0] keys = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // one tick strobe every four clocks, changed at the falling edge
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 3);
    end

    // matrix model: a pressed key joins its drive row to its sense column
    always_comb begin
        sense = '0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++)
                if (keys[5*r+c] && drive[r]) sense[c] = 1'b1;
    end

    keyscan_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sense(sense), .keysel(keysel),
        .psmode(psmode), .rd_done(rd_done), .host_wr(host_wr), .drive(drive),
        .key_img(key_img), .ps_flag(ps_flag), .req_n(req_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tk(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        #1;
    endtask

    task automatic pulse_read();
        @(negedge clk) rd_done = 1'b1;
        @(negedge clk) rd_done = 1'b0;
        #1;
    endtask

    function automatic logic [29:0] exp_img(logic [1:0] ks, logic [1:0] ps, logic [29:0] k);
        logic [29:0] m = '0;
        for (int r = 0; r < 6; r++) begin
            bit ok = !(r == 0 && ks != 2'b00) && !(r == 1 && ks[1]);
            bit hi = (ps == 2'b00) || (ps == 2'b11) || (ps == 2'b01 && r == 5)
                     || (ps == 2'b10 && r >= 4);
            if (ok && hi) m[5*r +: 5] = k[5*r +: 5];
        end
        return m;
    endfunction

    // {keysel, psmode, keys}
    localparam logic [33:0] VEC [7] = '{
        {2'b00, 2'b00, 30'h0000_0001},
        {2'b00, 2'b00, 30'h2000_0080},
        {2'b01, 2'b00, 30'h0000_1004},
        {2'b10, 2'b00, 30'h0200_0040},
        {2'b00, 2'b01, 30'h0800_0008},
        {2'b00, 2'b10, 30'h2040_8000},
        {2'b00, 2'b11, 30'h0000_0400}
    };

    initial begin
        #750000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk("R1 req_n at reset", 32'(req_n), 32'd1);
        chk("R1 key_img at reset", 32'(key_img), 32'd0);
        chk("R1 drive at reset", 32'(drive), 32'h3F);
        @(negedge clk) rst_n = 1'b1;
        tk(3);
        chk("R1 no scan after reset", 32'(req_n), 32'd1);

        // table of modes and key patterns
        foreach (VEC[i]) begin
            logic [1:0] ks = VEC[i][33:32];
            logic [1:0] ps = VEC[i][31:30];
            logic [29:0] k = VEC[i][29:0];
            keysel = ks;
            psmode = ps;
            tk(1);
            keys = k;
            tk(1);
            tk(576);
            chk("R3 req_n high at tick 576", 32'(req_n), 32'd1);
            tk(1);
            chk("R3 req_n low at tick 577", 32'(req_n), 32'd0);
            chk("R8 R9 R10 key image", 32'(key_img), 32'(exp_img(ks, ps, k)));
            chk("R11 ps_flag", 32'(ps_flag), 32'(ps != 2'b00));
            keys = '0;
            pulse_read();
            chk("R6 request released", 32'(req_n), 32'd1);
        end

        // freeze and host-write override
        keysel = 2'b00;
        psmode = 2'b00;
        tk(1);
        keys = 30'h0000_0100;
        tk(578);
        chk("R3 request for frozen test", 32'(req_n), 32'd0);
        keys = 30'h0000_0200;
        tk(700);
        chk("R5 image frozen", 32'(key_img), 32'h100);
        chk("R5 request still low", 32'(req_n), 32'd0);
        chk("R10 idle drive during hold", 32'(drive), 32'h3F);
        @(negedge clk) host_wr = 1'b1;
        #1 chk("R7 write forces req_n high", 32'(req_n), 32'd1);
        @(negedge clk) host_wr = 1'b0;
        #1 chk("R7 req_n low after write, no read", 32'(req_n), 32'd0);
        @(negedge clk) host_wr = 1'b1;
        keys = '0;
        pulse_read();
        @(negedge clk) host_wr = 1'b0;
        #1 chk("R6 R7 read inside write keeps req_n high", 32'(req_n), 32'd1);
        tk(700);
        chk("R2 no scan without keys", 32'(req_n), 32'd1);

        // stray read-done while idle
        pulse_read();
        chk("R6 stray read keeps image", 32'(key_img), 32'h100);
        chk("R6 stray read keeps request", 32'(req_n), 32'd1);

        // bounce: image differs between the two scans of a pair
        tk(1);
        keys = 30'h0000_0001;
        tk(1);
        tk(50);
        chk("R2 row 1 share drive", 32'(drive), 32'h02);
        tk(250);
        keys = 30'h0000_0002;
        tk(852);
        chk("R4 no request after mismatched pair", 32'(req_n), 32'd1);
        tk(1);
        chk("R4 request one pair later", 32'(req_n), 32'd0);
        chk("R4 R8 image after retry", 32'(key_img), 32'h2);
        keys = '0;
        pulse_read();

        // released before the second scan
        tk(1);
        keys = 30'h0000_4000;
        tk(1);
        tk(300);
        keys = '0;
        tk(900);
        chk("R4 give up after release", 32'(req_n), 32'd1);
        chk("R4 image untouched", 32'(key_img), 32'h2);

        // power-save idle levels; a key on a low row raises nothing
        psmode = 2'b01;
        tk(1);
        chk("R10 idle drive power-save 1", 32'(drive), 32'h20);
        chk("R11 ps_flag power-save 1", 32'(ps_flag), 32'd1);
        keys = 30'h0000_0004;
        tk(700);
        chk("R10 masked row ignored", 32'(req_n), 32'd1);
        keys = '0;
        psmode = 2'b10;
        #1 chk("R10 idle drive power-save 2", 32'(drive), 32'h30);
        psmode = 2'b00;
        #1 chk("R11 ps_flag normal", 32'(ps_flag), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule